// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses of one synchronous DRAM burst. A start pulse loads a starting column, a burst length code and a wrap order. From the next clock onward the block presents one column per cycle with a valid flag. It raises a last-beat flag on the final beat of a fixed-length burst.

For fixed lengths, the generator walks the aligned window that contains the start column. It does this either in sequential order or in interleaved order. In full-page mode it counts through every column of the row, wraps at the row end and keeps going until a stop request arrives. A stop request ends the burst early, and a new start pulse restarts it at once.

The block sits between the command sequencer, which issues the start and stop requests, and the column address path. It does not issue commands and it does not move data.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, valid_o and last_o stay low until the first start_i pulse.
- R2: In the cycle after start_i is sampled high, valid_o is high and col_o equals the start_col_i that was sampled. Any column value is accepted as a start.
- R3: The length code bl_i selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4 and 3 gives 8. Code 7 selects full page. Codes 4, 5 and 6 behave as code 3.
- R4: With wrap_i=0 and a fixed length BL, beat k (k = 0 to BL-1) shows two parts. The bits above log2(BL) come from the start column. The low log2(BL) bits are the start column plus k, modulo BL.
- R5: With wrap_i=1 and a fixed length, beat k shows the start column XOR k.
- R6: In full-page mode beat k shows (start + k) modulo 2^COL_W. The count wraps past the last column and continues until it is stopped. wrap_i has no effect in this mode.
- R7: last_o is high only on beat BL-1 of a fixed-length burst and never high in full-page mode. valid_o falls in the cycle after the last beat unless a new start arrives.
- R8: A burst length of 1 gives a single beat that shows the start column with last_o high.
- R9: When stop_i is sampled high during a burst, the beat shown in that cycle remains valid. valid_o is low from the next cycle and no further addresses appear.
- R10: A start_i pulse during a burst restarts it with the new inputs, and takes precedence over a stop_i in the same cycle.
- R11: Changes to start_col_i, bl_i and wrap_i after the start pulse have no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the current inputs |
| start_col_i | input | COL_W | Starting column |
| bl_i | input | 3 | Burst length code |
| wrap_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | End the running burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | col_o holds a beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
The assertions watch several properties on every cycle:
- the first beat after a start matches the sampled column;
- the single beat of a one-beat burst is flagged last;
- valid drops after a stop or a last beat;
- last never appears without valid or during a full-page burst;
- full-page addresses step by one each cycle.

The exact sequential and interleaved wrap orders within each window are shown only by the bench. It sweeps every start column for every fixed length in both orders. The bench also shows that mid-burst input changes are ignored, how a restart behaves when it collides with a stop, and how a full page wraps over the row end.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic [2:0] {
    LEN_1    = 3'd0,
    LEN_2    = 3'd1,
    LEN_4    = 3'd2,
    LEN_8    = 3'd3,
    LEN_PAGE = 3'd7
  } len_code_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } wrap_ord_e;
endpackage

// File: rtl/burst_cfg_dec.sv
module burst_cfg_dec
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       len_code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             page_o
);
  always_comb begin
    page_o = (len_code_i == LEN_PAGE);
    unique case (len_code_i)
      LEN_1:    mask_o = '0;
      LEN_2:    mask_o = COL_W'(1);
      LEN_4:    mask_o = COL_W'(3);
      LEN_PAGE: mask_o = '1;
      default:  mask_o = COL_W'(7); // 8 and reserved codes
    endcase
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             page_i,
  output logic             active_o,
  output logic [COL_W-1:0] beat_o,
  output logic             last_o
);
  logic             active_q;
  logic [COL_W-1:0] beat_q;

  assign last_o   = active_q && !page_i && (beat_q == mask_i);
  assign active_o = active_q;
  assign beat_o   = beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      beat_q   <= '0;
    end else if (active_q) begin
      if (stop_i || last_o) begin
        active_q <= 1'b0;
      end else begin
        beat_q <= beat_q + COL_W'(1); // full page wraps mod 2^COL_W
      end
    end
  end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] ilv_col;

  assign seq_col = (base_i & ~mask_i) | ((base_i + beat_i) & mask_i);
  assign ilv_col = base_i ^ (beat_i & mask_i);
  assign col_o   = ilv_i ? ilv_col : seq_col;
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_i,
  input  logic             wrap_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic [COL_W-1:0] base_q, mask_q;
  logic             page_q, ilv_q;
  logic [COL_W-1:0] beat;

  burst_cfg_dec #(.COL_W(COL_W)) u_dec (
    .len_code_i(bl_i),
    .mask_o    (dec_mask),
    .page_o    (dec_page)
  );

  // configuration is frozen at the start pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (start_i) begin
      base_q <= start_col_i;
      mask_q <= dec_mask;
      page_q <= dec_page;
      ilv_q  <= (wrap_i == ORD_ILV) && !dec_page;
    end
  end

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .mask_i  (mask_q),
    .page_i  (page_q),
    .active_o(valid_o),
    .beat_o  (beat),
    .last_o  (last_o)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_i(base_q),
    .beat_i(beat),
    .mask_i(mask_q),
    .ilv_i (ilv_q),
    .col_o (col_o)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       bl_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic page_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      page_seen_q <= 1'b0;
    else if (start_i) page_seen_q <= (bl_i == 3'd7);
  end

  assert_last_needs_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  assert_first_beat_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  assert_single_beat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && bl_i == 3'd0) |=> last_o);

  assert_stop_ends_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stop_i && !start_i) |=> !valid_o);

  assert_end_after_last_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  assert_page_no_last_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && page_seen_q) |-> !last_o);

  assert_page_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && page_seen_q && !stop_i && !start_i) |=>
      (valid_o && col_o == $past(col_o) + COL_W'(1)));
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .start_col_i(start_col_i),
  .bl_i       (bl_i),
  .stop_i     (stop_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .last_o     (last_o)
);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 8;
  localparam int NCOL = 1 << COL_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       bl_i = '0;
  logic             wrap_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  burst_col_gen #(.COL_W(COL_W)) u_dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int blen(input int code);
    if (code == 7) return NCOL;
    if (code > 3) return 8;
    return 1 << code;
  endfunction

  function automatic int exp_col(input int s, input int code, input int w, input int k);
    int m;
    if (code == 7) return (s + k) % NCOL;
    m = blen(code) - 1;
    if (w != 0) return s ^ k;
    return (s & ~m) | ((s + k) & m);
  endfunction

  task automatic kick(input int s, input int code, input int w);
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = COL_W'(s); bl_i = 3'(code); wrap_i = w[0];
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // checks a full fixed-length burst, optionally scrambling inputs mid-burst (R11)
  task automatic run_fixed(input int s, input int code, input int w, input bit scr);
    int n = blen(code);
    string req = (w != 0) ? "R5" : "R4";
    kick(s, code, w);
    if (scr) begin
      start_col_i = ~COL_W'(s); bl_i = 3'd7; wrap_i = ~w[0];
      req = "R11";
    end
    for (int k = 0; k < n; k++) begin
      check(valid_o === 1'b1, "R2 valid", int'(valid_o), 1);
      check(col_o === COL_W'(exp_col(s, code, w, k)), req, int'(col_o), exp_col(s, code, w, k));
      check(last_o === (k == n - 1), "R7 last", int'(last_o), int'(k == n - 1));
      @(negedge clk_i);
    end
    check(valid_o === 1'b0, "R7 end", int'(valid_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(valid_o === 1'b0, "R1 valid", int'(valid_o), 0);
    check(last_o === 1'b0, "R1 last", int'(last_o), 0);

    // R1 R4 R5 R3: sweep every start for each fixed length and both orders
    for (int code = 0; code < 4; code++)
      for (int w = 0; w < 2; w++)
        for (int s = 0; s < NCOL; s++)
          run_fixed(s, code, w, (s % 37) == 5);

    // R3: reserved codes behave as length 8
    for (int code = 4; code < 7; code++) run_fixed(13 + code, code, code & 1, 1'b0);

    // R8: single beat
    kick(77, 0, 0);
    check(col_o === 8'd77 && last_o === 1'b1, "R8", int'(col_o), 77);
    @(negedge clk_i);
    check(valid_o === 1'b0, "R8 end", int'(valid_o), 0);

    // R6: full page wraps over row end, wrap_i ignored, then stop
    kick(250, 7, 1);
    for (int k = 0; k < NCOL + 20; k++) begin
      check(col_o === COL_W'((250 + k) % NCOL), "R6 col", int'(col_o), (250 + k) % NCOL);
      check(valid_o === 1'b1 && last_o === 1'b0, "R6 flags", int'(last_o), 0);
      if (k == NCOL + 19) stop_i = 1'b1;
      @(negedge clk_i);
    end
    stop_i = 1'b0;
    check(valid_o === 1'b0, "R6 stop", int'(valid_o), 0);

    // R9: early stop on beat 2 of an 8-beat burst
    kick(5, 3, 0);
    @(negedge clk_i); @(negedge clk_i);
    stop_i = 1'b1;
    check(col_o === 8'd7 && valid_o === 1'b1, "R9 shown", int'(col_o), 7);
    @(negedge clk_i);
    stop_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(valid_o === 1'b0, "R9 quiet", int'(valid_o), 0);
      @(negedge clk_i);
    end

    // R10: restart with simultaneous stop
    kick(10, 3, 0);
    @(negedge clk_i); @(negedge clk_i);
    start_i = 1'b1; stop_i = 1'b1; start_col_i = 8'd201; bl_i = 3'd2; wrap_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; stop_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(valid_o === 1'b1 && col_o === COL_W'(201 ^ k), "R10", int'(col_o), 201 ^ k);
      check(last_o === (k == 3), "R10 last", int'(last_o), int'(k == 3));
      @(negedge clk_i);
    end
    check(valid_o === 1'b0, "R10 end", int'(valid_o), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule